// File: doc/BRIEF.md
# Lane Serializer with Output Polarity

This block turns a parallel transmit word into a single serial bit stream, one bit per clock. A word carries one, two or four character lanes. Every lane is made into a 10-bit character, and two characters make one 20-bit group. A new group is loaded every 20 clocks, and the bit with index 0 of each group leaves first.

Characters are formed in one of two ways. In direct mode the 10-bit value is already coded: it is the data byte plus two auxiliary bits. In bypass mode the block builds the character from the two auxiliary bits and the data byte in a fixed order. The block asks for input with a one-cycle request strobe. The source must present the word in the cycle after the strobe, and the block captures it at the end of that cycle.

An inversion input flips every serial bit. The block samples this input only at group boundaries, so a change never splits a group.

Top module: `lane_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_out` and `word_req` are 0. For the first 20 clocks after reset is released, `ser_out` is 0, which is an idle group.
- R2: After the idle group, a new 20-bit group begins exactly every 20 clocks. Group bit 0 goes out first, and within the group character 0 occupies bits 0 to 9.
- R3: With `wsel`=01 (two lanes), each group carries lane 0 and then lane 1 of a single word. `word_req` is high in the 19th clock of every group.
- R4: With `wsel`=00 (one lane), each group carries lane 0 of two successive words, the earlier word first. `word_req` is high in the 9th and 19th clock of every group.
- R5: With `wsel`=10 or 11 (four lanes), one word fills two successive groups in lane order 0, 1, 2, 3. `word_req` is high only in the 19th clock of the idle group and of every second group after it.
- R6: With `bypass`=1, a lane's character is sent in this order: `tx_aux` bit 2i, then `tx_aux` bit 2i+1, then `tx_byte` lane bits 7 down to 0. Data bit 0 goes out last.
- R7: With `bypass`=0, a lane's character is sent in this order: `tx_byte` lane bits 0 up to 7, then `tx_aux` bit 2i, then `tx_aux` bit 2i+1.
- R8: With `polarity`=1, every bit of a data group is inverted on `ser_out`.
- R9: A change on `polarity` takes effect at the first group that starts after the change. Bits of the group already in flight keep their old sense.
- R10: `word_req` is a single-cycle pulse. The word is captured at the clock edge that ends the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wsel | input | 2 | Lanes per word: 00 one, 01 two, 1x four |
| bypass | input | 1 | 1: assemble characters in bypass order |
| polarity | input | 1 | 1: invert the serial output |
| tx_byte | input | 32 | Data byte for each lane, lane i in bits 8i+7..8i |
| tx_aux | input | 8 | Two auxiliary bits per lane, lane i in bits 2i+1..2i |
| word_req | output | 1 | Request strobe for the next word |
| ser_out | output | 1 | Serial data out |

## Verification
The assertions assume that `wsel` stays constant between resets. They also assume that the source answers every request by presenting the word in the cycle that follows. The request-spacing checks depend on both points. The stimulus changes the width only while reset is asserted. It drives each word at the falling edge after the cycle that carried the strobe. The only input it changes mid-stream is `polarity`, and it does so in the middle of a group, so the checks can observe where the boundary falls.

// File: rtl/lane_serializer.sv
module lane_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  wsel,
  input  logic        bypass,
  input  logic        polarity,
  input  logic [31:0] tx_byte,
  input  logic [7:0]  tx_aux,
  output logic        word_req,
  output logic        ser_out
);
  localparam int CHW   = 10;
  localparam int GRP   = 2 * CHW;
  localparam int LANES = 4;

  logic [4:0]     cnt;
  logic [GRP-1:0] sh, hold;
  logic [CHW-1:0] lo;
  logic           half, pol_q;
  logic [CHW-1:0] ch [LANES];

  // index of the result = position in send order
  function automatic logic [CHW-1:0] mk_char(input logic [7:0] b, input logic [1:0] a,
                                             input logic byp);
    logic [CHW-1:0] c;
    if (byp) begin
      c[0] = a[0];
      c[1] = a[1];
      for (int k = 0; k < 8; k++) c[2+k] = b[7-k];
    end else begin
      c = {a[1], a[0], b};
    end
    return c;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ch[i] = mk_char(tx_byte[8*i +: 8], tx_aux[2*i +: 2], bypass);
  end

  wire one  = (wsel == 2'b00);
  wire quad = wsel[1];
  wire last = (cnt == 5'(GRP-1));
  wire mid  = (cnt == 5'(CHW-1));

  assign word_req = ((cnt == 5'(GRP-2)) && !(quad && half)) ||
                    (one && (cnt == 5'(CHW-2)));
  assign ser_out  = sh[0] ^ pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sh    <= '0;
      hold  <= '0;
      lo    <= '0;
      half  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      cnt <= last ? 5'd0 : cnt + 5'd1;
      if (one && mid) lo <= ch[0];
      if (last) begin
        pol_q <= polarity;
        if (one)               sh <= {ch[0], lo};
        else if (quad && half) sh <= hold;
        else                   sh <= {ch[1], ch[0]};
        if (quad && !half) hold <= {ch[3], ch[2]};
        half <= quad ? !half : 1'b0;
      end else begin
        sh <= {1'b0, sh[GRP-1:1]};
      end
    end
  end
endmodule

module lane_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_req,
  input logic [1:0] wsel,
  input logic [4:0] cnt,
  input logic       pol_q
);
  logic [6:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_req) begin
      gap  <= 7'd1;
      seen <= 1'b1;
    end else if (gap != 7'h7f) begin
      gap <= gap + 7'd1;
    end
  end

  p_req_gap_w2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && seen && wsel == 2'b01) |-> gap == 7'd20);
  p_req_gap_w1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && seen && wsel == 2'b00) |-> gap == 7'd10);
  p_req_gap_w4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && seen && wsel[1]) |-> gap == 7'd40);
  p_pol_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_q) |-> cnt == 5'd0);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |=> !word_req);
endmodule

bind lane_serializer lane_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_req(word_req), .wsel(wsel), .cnt(cnt), .pol_q(pol_q)
);

// File: tb/lane_serializer_tb.sv
`timescale 1ns/1ps
module lane_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wsel = 2'b01;
  logic        bypass = 1'b0;
  logic        polarity = 1'b0;
  logic [31:0] tx_byte = '0;
  logic [7:0]  tx_aux = '0;
  logic        word_req, ser_out;

  int vectors = 0;
  int fails = 0;
  bit running;

  lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .bypass(bypass), .polarity(polarity),
    .tx_byte(tx_byte), .tx_aux(tx_aux), .word_req(word_req), .ser_out(ser_out)
  );

  always #4 clk = ~clk;

  localparam int NSAMP = 180;

  function automatic int f_byte(int k, int i);
    return (k * 37 + i * 91 + 5) % 256;
  endfunction
  function automatic int f_aux(int k, int i);
    return (k * 3 + i) % 4;
  endfunction
  // bit j of a character in send order, computed from the requirement text
  function automatic bit f_bit(int k, int i, int j, bit byp);
    int b = f_byte(k, i);
    int a = f_aux(k, i);
    if (byp) begin
      if (j < 2) return bit'((a >> j) & 1);      // R6
      return bit'((b >> (9 - j)) & 1);
    end
    if (j < 8) return bit'((b >> j) & 1);        // R7
    return bit'((a >> (j - 8)) & 1);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input int j);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sample %0d: actual %0b expected %0b", tag, j, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] w, input bit byp, input bit pol, input bit flip);
    int nch, nw, k, nreq;
    bit prev_req, cur_pol;
    string tag;
    nch = (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    nw  = 160 / (10 * nch);
    rst_n = 1'b0;
    wsel = w; bypass = byp; polarity = pol;
    repeat (3) @(negedge clk);
    check(ser_out, 1'b0, "R1 reset ser_out", -1);
    check(word_req, 1'b0, "R1 reset word_req", -1);
    rst_n = 1'b1;
    running = 1'b1;
    k = 0; nreq = 0; prev_req = 1'b0;
    tag = (w == 2'b00) ? "R4" : (w == 2'b01) ? "R3" : "R5";
    fork
      begin : sampler
        for (int j = 0; j < NSAMP; j++) begin
          bit exp;
          if (j < 20) begin
            exp = 1'b0;
            check(ser_out, exp, "R1 idle group", j);
          end else begin
            int s = j - 20;
            int c = s / 10;
            int g = s / 20;
            cur_pol = pol;
            if (flip && (20 + 20 * g > 65)) cur_pol = ~pol;   // R9
            exp = f_bit(c / nch, c % nch, s % 10, byp) ^ cur_pol;  // R2 R8
            check(ser_out, exp, {tag, byp ? " R6" : " R7", flip ? " R9" : " R8 R2"}, j);
          end
          if (word_req) nreq++;
          if (word_req && prev_req) check(1'b1, 1'b0, "R10 req pulse", j);
          prev_req = word_req;
          if (flip && j == 65) polarity = ~pol;
          @(negedge clk);
        end
        running = 1'b0;
      end
      begin : feeder
        while (running) begin
          if (word_req && k < nw) begin
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
              tx_byte[8*i +: 8] = 8'(f_byte(k, i));
              tx_aux[2*i +: 2]  = 2'(f_aux(k, i));
            end
            k++;
          end
          @(negedge clk);
        end
      end
    join
    vectors++;
    begin
      int exp_req = (w == 2'b00) ? 18 : (w == 2'b01) ? 9 : 5;
      if (nreq != exp_req) begin
        fails++;
        $display("FAIL %s request count: actual %0d expected %0d", tag, nreq, exp_req);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          run(2'(w == 2 ? 2 : w), bit'(b), bit'(p), 1'b0);
    run(2'b01, 1'b0, 1'b0, 1'b1);   // R9 mid-group polarity change
    run(2'b11, 1'b1, 1'b1, 1'b1);   // R5 code 11, R9 back to normal sense
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule